// File: doc/BRIEF.md
# Phase-Timed Parallel Output Port

This block is the parallel output port of a small 8-bit controller core. The core's machine cycle is six states, S1 to S6, and each state has two clock phases, P1 and P2. One machine cycle is therefore twelve oscillator clocks. A sequencer inside the block generates this state and phase count and brings it out, so the surrounding core and a testbench can line up with it.

The core writes to the port in the final machine cycle of an instruction. It can write a whole byte, or set or clear one bit chosen by an index. The write goes into the port latch only in S6P2. An output buffer passes the latch to the pin in phase 1 and holds it through phase 2, so a new value reaches the pin at S1P1 of the next machine cycle. When a pin bit rises from 0 to 1, a per-bit strong-pullup enable pulses for S1P1 and S1P2 of that cycle. A parameter turns this pulse on or off for each instance. The core can read the latch directly, and it can read a synchronised copy of the external pin levels.

Top module: `phased_port`

## Requirements
- R1: The sequencer runs through state 1 to state 6, with phase 1 then phase 2 in each state. One full cycle is 12 clocks. Reset puts it at state 1, phase 1. `state_num` reports the state as 1 to 6, and `phase2` is 0 in phase 1 and 1 in phase 2.
- R2: After reset, the latch and `pin_out` are all ones and `pullup_en` is all zeros.
- R3: A write strobe changes the latch only at the clock edge that ends S6P2. Strobes seen in any other state or phase have no effect.
- R4: `wr_byte` loads `wr_data` into all latch bits. `wr_bit` writes `bit_val` into the latch bit selected by `bit_sel` and leaves the other bits alone. If both strobes are high, the byte write wins.
- R5: During phase 1, `pin_out` shows the latch. During phase 2 it holds the value it had in the preceding phase 1. A value written at S6P2 therefore appears one clock later, at S1P1.
- R6: For each bit that goes from 0 to 1 on `pin_out`, `pullup_en` is high during S1P1 and S1P2 of that cycle and low at all other times. A falling bit or an unchanged bit produces no pulse.
- R7: With `STRONG_PU` = 0, `pullup_en` is always zero.
- R8: `latch_rd` returns the latch contents. `pin_rd` returns `pin_in` through two flops, so a change on `pin_in` becomes visible two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one phase per clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_byte | input | 1 | Whole-byte write strobe |
| wr_bit | input | 1 | Single-bit write strobe |
| bit_sel | input | $clog2(WIDTH) | Index of the bit to write |
| bit_val | input | 1 | Value to write into the selected bit |
| wr_data | input | WIDTH | Byte write data |
| pin_in | input | WIDTH | External pin levels |
| state_num | output | $clog2(STATES+1) | Current state, 1 to 6 |
| phase2 | output | 1 | High during phase 2 |
| pin_out | output | WIDTH | Value driven on the pins |
| pullup_en | output | WIDTH | Per-bit strong-pullup enable |
| latch_rd | output | WIDTH | Latch read path |
| pin_rd | output | WIDTH | Synchronised pin read path |

## Verification
The hardest case to reach from the ports is a write that lands exactly in the one S6P2 clock, followed by observing the pin in the single following phase and the pullup over the next two phases. The bench gets there by polling `state_num` and `phase2` at falling edges until it sees S6P2. It raises the strobe at that falling edge and samples the next three falling edges. Strobes placed in S3P1 and S6P1 show that a write is ignored when it misses the window.

// File: rtl/phased_port.sv
module phased_port #(
  parameter int WIDTH     = 8,
  parameter int STATES    = 6,
  parameter bit STRONG_PU = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_byte,
  input  logic                       wr_bit,
  input  logic [$clog2(WIDTH)-1:0]   bit_sel,
  input  logic                       bit_val,
  input  logic [WIDTH-1:0]           wr_data,
  input  logic [WIDTH-1:0]           pin_in,
  output logic [$clog2(STATES+1)-1:0] state_num,
  output logic                       phase2,
  output logic [WIDTH-1:0]           pin_out,
  output logic [WIDTH-1:0]           pullup_en,
  output logic [WIDTH-1:0]           latch_rd,
  output logic [WIDTH-1:0]           pin_rd
);
  localparam int SW = $clog2(STATES+1);
  localparam logic [SW-1:0] LAST_ST = SW'(STATES-1);

  logic [SW-1:0]    st;
  logic             ph;
  logic [WIDTH-1:0] latch_q, latch_nx, obuf_q, sync1_q, sync2_q;
  logic             last_phase, first_state;

  assign last_phase  = (st == LAST_ST) && ph;
  assign first_state = (st == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0;
      ph <= 1'b0;
    end else begin
      ph <= ~ph;
      if (ph) st <= (st == LAST_ST) ? '0 : st + 1'b1;
    end
  end

  assign state_num = st + 1'b1;
  assign phase2    = ph;

  always_comb begin
    latch_nx = latch_q;
    if (wr_byte)     latch_nx = wr_data;
    else if (wr_bit) latch_nx[bit_sel] = bit_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '1;
      obuf_q  <= '1;
    end else begin
      if (last_phase) latch_q <= latch_nx;
      if (!ph)        obuf_q  <= latch_q;
    end
  end

  assign pin_out  = ph ? obuf_q : latch_q;
  assign latch_rd = latch_q;

  generate
    if (STRONG_PU) begin : g_pu
      logic [WIDTH-1:0] pu_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                pu_q <= '0;
        else if (last_phase)       pu_q <= latch_nx & ~latch_q;
        else if (first_state && ph) pu_q <= '0;
      end
      assign pullup_en = pu_q;
    end else begin : g_no_pu
      assign pullup_en = '0;
      a_r7_no_pullup: assert property (@(posedge clk) disable iff (!rst_n)
        pullup_en == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end
  assign pin_rd = sync2_q;

  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    last_phase |=> (state_num == 1 && !phase2));
  a_r3_latch_window: assert property (@(posedge clk) disable iff (!rst_n)
    !last_phase |=> $stable(latch_rd));
  a_r5_p2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    phase2 |-> pin_out == $past(pin_out));
  a_r6_pu_state1: assert property (@(posedge clk) disable iff (!rst_n)
    (pullup_en != '0) |-> state_num == 1);
  a_r6_pu_high_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (pullup_en & ~pin_out) == '0);
endmodule

// File: tb/phased_port_tb_top.sv
module phased_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_byte = 1'b0, wr_bit = 1'b0, bit_val = 1'b0;
  logic [2:0] bit_sel = '0;
  logic [7:0] wr_data = '0, pin_in = '0;
  logic [2:0] state_num, np_state;
  logic phase2, np_phase2;
  logic [7:0] pin_out, pullup_en, latch_rd, pin_rd;
  logic [7:0] np_pin, np_pu, np_latch, np_rd;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  phased_port dut_i (.clk, .rst_n, .wr_byte, .wr_bit, .bit_sel, .bit_val,
    .wr_data, .pin_in, .state_num, .phase2, .pin_out, .pullup_en, .latch_rd, .pin_rd);

  phased_port #(.STRONG_PU(1'b0)) dut_np_i (.clk, .rst_n, .wr_byte, .wr_bit,
    .bit_sel, .bit_val, .wr_data, .pin_in, .state_num(np_state), .phase2(np_phase2),
    .pin_out(np_pin), .pullup_en(np_pu), .latch_rd(np_latch), .pin_rd(np_rd));

  // op: 1 byte write, 2 bit write, 3 both strobes
  localparam logic [1:0] V_OP [8]  = '{2'd1, 2'd1, 2'd2, 2'd2, 2'd1, 2'd2, 2'd1, 2'd3};
  localparam logic [2:0] V_IDX[8]  = '{3'd0, 3'd0, 3'd1, 3'd7, 3'd0, 3'd7, 3'd0, 3'd0};
  localparam logic       V_VAL[8]  = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [7:0] V_DAT[8]  = '{8'h00, 8'hA5, 8'h00, 8'h00, 8'h5A, 8'h00, 8'hFF, 8'h00};
  localparam logic [7:0] V_EXP[8]  = '{8'h00, 8'hA5, 8'hA7, 8'h27, 8'h5A, 8'hDA, 8'hFF, 8'h00};
  localparam logic [7:0] V_PU [8]  = '{8'h00, 8'hA5, 8'h02, 8'h00, 8'h58, 8'h80, 8'h25, 8'h00};

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_for(input int s, input logic p);
    while (!(state_num == 3'(s) && phase2 == p)) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1, R2: reset state
    chk("R1 state after reset", {4'd0, state_num, phase2}, 8'h02);
    chk("R2 pin after reset", pin_out, 8'hFF);
    chk("R2 latch after reset", latch_rd, 8'hFF);
    chk("R2 pullup after reset", pullup_en, 8'h00);

    // R1: twelve clocks per machine cycle
    begin
      int n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!(state_num == 3'd1 && !phase2) && n < 40);
      chk("R1 clocks per cycle", 8'(n), 8'd12);
    end

    // R3..R7: vector table, write placed at S6P2
    for (int i = 0; i < 8; i++) begin
      logic [7:0] prev;
      wait_for(6, 1'b1);
      prev = pin_out;
      wr_byte = V_OP[i][0];
      wr_bit  = V_OP[i][1];
      bit_sel = V_IDX[i];
      bit_val = V_VAL[i];
      wr_data = V_DAT[i];
      chk("R5 pin before edge", pin_out, prev);
      @(negedge clk);
      wr_byte = 1'b0;
      wr_bit  = 1'b0;
      chk("R4 latch after write", latch_rd, V_EXP[i]);
      chk("R5 pin at S1P1", pin_out, V_EXP[i]);
      chk("R6 pullup at S1P1", pullup_en, V_PU[i]);
      chk("R7 no pullup variant", np_pu, 8'h00);
      @(negedge clk);
      chk("R5 pin at S1P2", pin_out, V_EXP[i]);
      chk("R6 pullup at S1P2", pullup_en, V_PU[i]);
      @(negedge clk);
      chk("R6 pullup after S1P2", pullup_en, 8'h00);
    end

    // R3: strobes outside S6P2 are ignored
    wait_for(3, 1'b0);
    wr_byte = 1'b1;
    wr_data = 8'h3C;
    @(negedge clk);
    wr_byte = 1'b0;
    wait_for(6, 1'b0);
    wr_bit = 1'b1;
    bit_sel = 3'd4;
    bit_val = 1'b1;
    @(negedge clk);
    wr_bit = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R3 latch ignores early strobes", latch_rd, 8'h00);
    chk("R3 pin ignores early strobes", pin_out, 8'h00);
    chk("R3 no pullup from ignored write", pullup_en, 8'h00);

    // R8: pin read synchroniser latency
    pin_in = 8'h96;
    @(negedge clk);
    chk("R8 pin_rd after one clock", pin_rd, 8'h00);
    @(negedge clk);
    chk("R8 pin_rd after two clocks", pin_rd, 8'h96);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule